// File: doc/BRIEF.md
# Row-Hit-First DRAM Command Scheduler

This block sits between a request source and a DRAM command path. It keeps a small buffer of pending memory requests that span several banks. It also keeps a register per bank holding that bank's open row. Every cycle it looks at the buffer and works out the command each request needs next:

- an activate when the bank is closed,
- a read or write when the bank already holds the requested row,
- a precharge when the bank holds some other row.

It then issues at most one of these commands. A request stays in the buffer until its read or write goes out.

Two selection policies are available on a mode pin.

- **First-ready mode.** Column commands (read or write) beat row commands (activate or precharge). Within each of those two groups the earlier arrival wins. This keeps row-buffer hits flowing while older requests wait for their rows.
- **Plain arrival-order mode.** The earliest pending request is served, with nothing else considered.

Arrival order comes from a wrapping stamp that each entry stores. Each bank has a busy input that stands in for its timing counters. While a bank's busy input is high, no command goes to that bank.

Top module: `rowhit_sched`

## Requirements
- R1: After reset the buffer is empty, every bank is closed, `req_ready` is high and `cmd_valid` is low.
- R2: A request is stored on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low exactly when DEPTH requests are pending. A request offered while the buffer is full is not stored and never produces a command.
- R3: The command chosen for a request depends on the state of its bank. A closed bank gives activate (`cmd_kind`=0). A bank open on the same row gives read (2) when `req_write`=0 and write (3) when `req_write`=1. A bank open on a different row gives precharge (1). Every command carries the request's `cmd_id`, bank and row.
- R4: An issued activate marks its bank open on `cmd_row`. An issued precharge marks its bank closed.
- R5: At most one command is issued per cycle. A request leaves the buffer in the cycle its read or write is issued, and that command carries the request's column on `cmd_col`.
- R6: With `fr_mode`=1, the oldest eligible request needing a column command is chosen whenever one exists. Otherwise the oldest eligible request needing a row command is chosen.
- R7: With `fr_mode`=0, only the oldest pending request is served. If its bank is busy, no command is issued that cycle.
- R8: No command is issued to a bank whose `bank_busy` bit is high in that cycle.
- R9: Age order stays correct when the arrival stamp wraps around from its maximum value to zero.
- R10: With no pending request, `cmd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fr_mode | input | 1 | 1 = hit-first policy, 0 = strict arrival order |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Buffer has a free entry |
| req_bank | input | NB_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_write | input | 1 | 1 = write, 0 = read |
| req_id | input | ID_W | Request identifier |
| bank_busy | input | NUM_BANKS | Per-bank busy flag, one bit per bank |
| cmd_valid | output | 1 | A command is issued this cycle |
| cmd_kind | output | 2 | 0 activate, 1 precharge, 2 read, 3 write |
| cmd_bank | output | NB_W | Bank of the command |
| cmd_row | output | ROW_W | Row of the request behind the command |
| cmd_col | output | COL_W | Column of the request behind the command |
| cmd_id | output | ID_W | Identifier of the request behind the command |

## Verification
The bench instantiates the block with four banks, an eight-entry buffer and a 5-bit arrival stamp. A stamp that narrow wraps after 32 arrivals, so the bench can drive the wrap within a short run and hold four requests whose stamps straddle it. Eight entries over four banks let the bench fill the buffer, offer a request while full, and then drain a mix of conflicts and hits. The same four-request load is run under both policies, so one command trace can be compared against the other.

// File: rtl/sched_pkg.sv
package sched_pkg;

   typedef enum logic [1:0] {
      CMD_ACT = 2'd0,
      CMD_PRE = 2'd1,
      CMD_RD  = 2'd2,
      CMD_WR  = 2'd3
   } cmd_kind_e;

endpackage

// File: rtl/sched_bank_table.sv
module sched_bank_table #(
   parameter int NUM_BANKS = 4,
   parameter int ROW_W     = 8,
   parameter int NB_W      = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 upd_en,
   input  logic                 upd_open,
   input  logic [NB_W-1:0]      upd_bank,
   input  logic [ROW_W-1:0]     upd_row,
   output logic [NUM_BANKS-1:0] open_vld,
   output logic [ROW_W-1:0]     open_row [NUM_BANKS]
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_vld <= '0;
         for (int b = 0; b < NUM_BANKS; b++) open_row[b] <= '0;
      end else if (upd_en) begin
         open_vld[upd_bank] <= upd_open;
         if (upd_open) open_row[upd_bank] <= upd_row;
      end
   end

endmodule

// File: rtl/sched_req_store.sv
module sched_req_store #(
   parameter int DEPTH = 8,
   parameter int NB_W  = 2,
   parameter int ROW_W = 8,
   parameter int COL_W = 6,
   parameter int ID_W  = 4,
   parameter int AGE_W = 5,
   parameter int IDX_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [NB_W-1:0]    in_bank,
   input  logic [ROW_W-1:0]   in_row,
   input  logic [COL_W-1:0]   in_col,
   input  logic               in_write,
   input  logic [ID_W-1:0]    in_id,
   input  logic               ret_en,
   input  logic [IDX_W-1:0]   ret_idx,
   output logic [DEPTH-1:0]   e_vld,
   output logic [NB_W-1:0]    e_bank  [DEPTH],
   output logic [ROW_W-1:0]   e_row   [DEPTH],
   output logic [COL_W-1:0]   e_col   [DEPTH],
   output logic [DEPTH-1:0]   e_write,
   output logic [ID_W-1:0]    e_id    [DEPTH],
   output logic [AGE_W-1:0]   e_age   [DEPTH]
);

   logic [AGE_W-1:0] stamp;
   logic             slot_found;
   logic [IDX_W-1:0] slot_idx;
   logic             take;

   // lowest free slot
   always_comb begin
      slot_found = 1'b0;
      slot_idx   = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (!e_vld[i]) begin
            slot_found = 1'b1;
            slot_idx   = IDX_W'(i);
         end
      end
   end

   assign in_ready = slot_found;
   assign take     = in_valid && slot_found;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stamp   <= '0;
         e_vld   <= '0;
         e_write <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            e_bank[i] <= '0;
            e_row[i]  <= '0;
            e_col[i]  <= '0;
            e_id[i]   <= '0;
            e_age[i]  <= '0;
         end
      end else begin
         if (take) begin
            stamp             <= stamp + AGE_W'(1);
            e_vld[slot_idx]   <= 1'b1;
            e_bank[slot_idx]  <= in_bank;
            e_row[slot_idx]   <= in_row;
            e_col[slot_idx]   <= in_col;
            e_write[slot_idx] <= in_write;
            e_id[slot_idx]    <= in_id;
            e_age[slot_idx]   <= stamp;
         end
         if (ret_en) e_vld[ret_idx] <= 1'b0;
      end
   end

endmodule

// File: rtl/sched_age_pick.sv
module sched_age_pick #(
   parameter int N     = 8,
   parameter int AGE_W = 5,
   parameter int IDX_W = 3
) (
   input  logic [N-1:0]     mask,
   input  logic [AGE_W-1:0] age [N],
   output logic             found,
   output logic [IDX_W-1:0] idx
);

   // a precedes b when the wrapped difference is negative
   function automatic logic precedes(input logic [AGE_W-1:0] a,
                                     input logic [AGE_W-1:0] b);
      logic [AGE_W-1:0] d;
      d = a - b;
      return d[AGE_W-1];
   endfunction

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = 0; i < N; i++) begin
         if (mask[i] && (!found || precedes(age[i], age[idx]))) begin
            found = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/rowhit_sched.sv
module rowhit_sched
   import sched_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int DEPTH     = 8,
   parameter int ROW_W     = 8,
   parameter int COL_W     = 6,
   parameter int ID_W      = 4,
   parameter int AGE_W     = 5,
   localparam int NB_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 fr_mode,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [NB_W-1:0]      req_bank,
   input  logic [ROW_W-1:0]     req_row,
   input  logic [COL_W-1:0]     req_col,
   input  logic                 req_write,
   input  logic [ID_W-1:0]      req_id,
   input  logic [NUM_BANKS-1:0] bank_busy,
   output logic                 cmd_valid,
   output logic [1:0]           cmd_kind,
   output logic [NB_W-1:0]      cmd_bank,
   output logic [ROW_W-1:0]     cmd_row,
   output logic [COL_W-1:0]     cmd_col,
   output logic [ID_W-1:0]      cmd_id
);

   // elaboration-time parameter checks
   if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two of at least 2");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end
   if ((1 << AGE_W) < 2 * DEPTH) begin : g_bad_age
      $error("AGE_W too narrow for wrapped age comparison");
   end
   if (ROW_W < 1 || COL_W < 1 || ID_W < 1) begin : g_bad_fields
      $error("field widths must be positive");
   end

   logic [DEPTH-1:0]     e_vld;
   logic [NB_W-1:0]      e_bank  [DEPTH];
   logic [ROW_W-1:0]     e_row   [DEPTH];
   logic [COL_W-1:0]     e_col   [DEPTH];
   logic [DEPTH-1:0]     e_write;
   logic [ID_W-1:0]      e_id    [DEPTH];
   logic [AGE_W-1:0]     e_age   [DEPTH];
   logic [NUM_BANKS-1:0] open_vld;
   logic [ROW_W-1:0]     open_row [NUM_BANKS];

   logic [DEPTH-1:0]     ent_open, ent_hit, ent_free;
   logic [DEPTH-1:0]     col_mask, row_mask;
   logic                 col_found, row_found, old_found;
   logic [IDX_W-1:0]     col_idx, row_idx, old_idx;
   logic                 sel_ok;
   logic [IDX_W-1:0]     sel_idx;
   cmd_kind_e            sel_kind;
   logic                 ret_en;
   logic                 upd_en;

   sched_req_store #(
      .DEPTH(DEPTH), .NB_W(NB_W), .ROW_W(ROW_W), .COL_W(COL_W),
      .ID_W(ID_W), .AGE_W(AGE_W), .IDX_W(IDX_W)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (req_valid),
      .in_ready (req_ready),
      .in_bank  (req_bank),
      .in_row   (req_row),
      .in_col   (req_col),
      .in_write (req_write),
      .in_id    (req_id),
      .ret_en   (ret_en),
      .ret_idx  (sel_idx),
      .e_vld    (e_vld),
      .e_bank   (e_bank),
      .e_row    (e_row),
      .e_col    (e_col),
      .e_write  (e_write),
      .e_id     (e_id),
      .e_age    (e_age)
   );

   sched_bank_table #(
      .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .NB_W(NB_W)
   ) u_banks (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd_en   (upd_en),
      .upd_open (sel_kind == CMD_ACT),
      .upd_bank (e_bank[sel_idx]),
      .upd_row  (e_row[sel_idx]),
      .open_vld (open_vld),
      .open_row (open_row)
   );

   // per-entry classification against its bank's row buffer
   for (genvar g = 0; g < DEPTH; g++) begin : g_class
      assign ent_open[g] = open_vld[e_bank[g]];
      assign ent_hit[g]  = ent_open[g] && (open_row[e_bank[g]] == e_row[g]);
      assign ent_free[g] = e_vld[g] && !bank_busy[e_bank[g]];
      assign col_mask[g] = ent_free[g] && ent_hit[g];
      assign row_mask[g] = ent_free[g] && !ent_hit[g];
   end

   sched_age_pick #(.N(DEPTH), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_pick_col (
      .mask (col_mask), .age (e_age), .found (col_found), .idx (col_idx)
   );

   sched_age_pick #(.N(DEPTH), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_pick_row (
      .mask (row_mask), .age (e_age), .found (row_found), .idx (row_idx)
   );

   sched_age_pick #(.N(DEPTH), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_pick_old (
      .mask (e_vld), .age (e_age), .found (old_found), .idx (old_idx)
   );

   always_comb begin
      sel_ok  = 1'b0;
      sel_idx = '0;
      if (fr_mode) begin
         if (col_found) begin
            sel_ok  = 1'b1;
            sel_idx = col_idx;
         end else if (row_found) begin
            sel_ok  = 1'b1;
            sel_idx = row_idx;
         end
      end else if (old_found && ent_free[old_idx]) begin
         sel_ok  = 1'b1;
         sel_idx = old_idx;
      end
   end

   always_comb begin
      if (ent_hit[sel_idx])       sel_kind = e_write[sel_idx] ? CMD_WR : CMD_RD;
      else if (ent_open[sel_idx]) sel_kind = CMD_PRE;
      else                        sel_kind = CMD_ACT;
   end

   assign ret_en    = sel_ok && ent_hit[sel_idx];
   assign upd_en    = sel_ok && !ent_hit[sel_idx];

   assign cmd_valid = sel_ok;
   assign cmd_kind  = sel_kind;
   assign cmd_bank  = e_bank[sel_idx];
   assign cmd_row   = e_row[sel_idx];
   assign cmd_col   = e_col[sel_idx];
   assign cmd_id    = e_id[sel_idx];

endmodule

// File: rtl/sched_checker.sv
module sched_checker #(
   parameter int NUM_BANKS = 4,
   parameter int DEPTH     = 8,
   parameter int ROW_W     = 8,
   parameter int NB_W      = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_valid,
   input logic                 req_ready,
   input logic [NUM_BANKS-1:0] bank_busy,
   input logic                 cmd_valid,
   input logic [1:0]           cmd_kind,
   input logic [NB_W-1:0]      cmd_bank,
   input logic [ROW_W-1:0]     cmd_row
);

   localparam int OCC_W = $clog2(DEPTH + 1);
   localparam logic [OCC_W-1:0] OCC_MAX = OCC_W'(DEPTH);

   logic [OCC_W-1:0]     occ;
   logic [NUM_BANKS-1:0] sh_open;
   logic [ROW_W-1:0]     sh_row [NUM_BANKS];
   logic                 acc, ret;

   assign acc = req_valid && req_ready;
   assign ret = cmd_valid && cmd_kind[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         occ     <= '0;
         sh_open <= '0;
         for (int b = 0; b < NUM_BANKS; b++) sh_row[b] <= '0;
      end else begin
         if (acc && !ret)      occ <= occ + OCC_W'(1);
         else if (!acc && ret) occ <= occ - OCC_W'(1);
         if (cmd_valid && !cmd_kind[1]) begin
            sh_open[cmd_bank] <= (cmd_kind == 2'd0);
            if (cmd_kind == 2'd0) sh_row[cmd_bank] <= cmd_row;
         end
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= OCC_MAX); // R2
   AST_READY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready == (occ != OCC_MAX)); // R2
   AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> !bank_busy[cmd_bank]); // R8
   AST_COL_ON_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_kind[1]) |-> (sh_open[cmd_bank] && sh_row[cmd_bank] == cmd_row)); // R3
   AST_ACT_ON_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_kind == 2'd0) |-> !sh_open[cmd_bank]); // R4
   AST_PRE_ON_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_kind == 2'd1) |-> (sh_open[cmd_bank] && sh_row[cmd_bank] != cmd_row)); // R3
   AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == '0) |-> !cmd_valid); // R10

endmodule

bind rowhit_sched sched_checker #(
   .NUM_BANKS(NUM_BANKS), .DEPTH(DEPTH), .ROW_W(ROW_W), .NB_W(NB_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .bank_busy (bank_busy),
   .cmd_valid (cmd_valid),
   .cmd_kind  (cmd_kind),
   .cmd_bank  (cmd_bank),
   .cmd_row   (cmd_row)
);

// File: tb/sim_rowhit_sched.sv
`timescale 1ns/1ps
module sim_rowhit_sched;

   localparam int NB = 4;
   localparam int DP = 8;
   localparam int RW = 8;
   localparam int CW = 6;
   localparam int IW = 4;
   localparam int AW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fr_mode = 1'b1;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [1:0]    req_bank = '0;
   logic [RW-1:0] req_row = '0;
   logic [CW-1:0] req_col = '0;
   logic          req_write = 1'b0;
   logic [IW-1:0] req_id = '0;
   logic [NB-1:0] bank_busy = '0;
   logic          cmd_valid;
   logic [1:0]    cmd_kind;
   logic [1:0]    cmd_bank;
   logic [RW-1:0] cmd_row;
   logic [CW-1:0] cmd_col;
   logic [IW-1:0] cmd_id;

   int  checks = 0;
   int  fails = 0;
   bit  done = 1'b0;
   int  col_cnt;
   bit  saw_rejected, bad_col, got;
   logic [IW-1:0] last_id;
   logic [8:0] ev;

   always #2 clk = ~clk;   // 250 MHz

   rowhit_sched #(
      .NUM_BANKS(NB), .DEPTH(DP), .ROW_W(RW), .COL_W(CW), .ID_W(IW), .AGE_W(AW)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .fr_mode(fr_mode),
      .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank),
      .req_row(req_row), .req_col(req_col), .req_write(req_write), .req_id(req_id),
      .bank_busy(bank_busy), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
      .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_id(cmd_id)
   );

   // {valid, kind, bank, id}; kind 0 act, 1 pre, 2 rd, 3 wr
   // rows 0..8 hit-first policy, rows 9..17 arrival-order policy
   localparam logic [8:0] EXP_TAB [18] = '{
      {1'b1, 2'd0, 2'd0, 4'd0},
      {1'b1, 2'd2, 2'd0, 4'd0},
      {1'b1, 2'd3, 2'd0, 4'd2},
      {1'b1, 2'd0, 2'd1, 4'd1},
      {1'b1, 2'd3, 2'd1, 4'd1},
      {1'b1, 2'd1, 2'd0, 4'd3},
      {1'b1, 2'd0, 2'd0, 4'd3},
      {1'b1, 2'd2, 2'd0, 4'd3},
      {1'b0, 2'd0, 2'd0, 4'd0},
      {1'b1, 2'd0, 2'd0, 4'd0},
      {1'b1, 2'd2, 2'd0, 4'd0},
      {1'b1, 2'd0, 2'd1, 4'd1},
      {1'b1, 2'd3, 2'd1, 4'd1},
      {1'b1, 2'd3, 2'd0, 4'd2},
      {1'b1, 2'd1, 2'd0, 4'd3},
      {1'b1, 2'd0, 2'd0, 4'd3},
      {1'b1, 2'd2, 2'd0, 4'd3},
      {1'b0, 2'd0, 2'd0, 4'd0}
   };

   task automatic check(input bit ok, input string tag,
                        input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   task automatic do_reset();
      rst_n     = 1'b0;
      req_valid = 1'b0;
      bank_busy = '0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   task automatic push(input logic [1:0] b, input logic [RW-1:0] r,
                       input logic [CW-1:0] c, input logic w, input logic [IW-1:0] id);
      req_bank  = b;
      req_row   = r;
      req_col   = c;
      req_write = w;
      req_id    = id;
      req_valid = 1'b1;
      @(posedge clk);
      #1 req_valid = 1'b0;
   endtask

   task automatic load_set();
      push(2'd0, 8'd5, 6'd1, 1'b0, 4'd0);
      push(2'd1, 8'd3, 6'd2, 1'b1, 4'd1);
      push(2'd0, 8'd5, 6'd3, 1'b1, 4'd2);
      push(2'd0, 8'd7, 6'd4, 1'b0, 4'd3);
   endtask

   initial begin
      #400000;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      // R1: reset state
      do_reset();
      @(negedge clk);
      check(req_ready === 1'b1, "R1 ready after reset", req_ready, 1);
      check(cmd_valid === 1'b0, "R1 no command after reset", cmd_valid, 0);
      @(posedge clk); #1;

      // R8: busy bank gets nothing, other bank proceeds
      do_reset();
      fr_mode   = 1'b1;
      bank_busy = 4'b0100;
      push(2'd2, 8'd1, 6'd0, 1'b0, 4'd5);
      @(negedge clk);
      check(cmd_valid === 1'b0, "R8 busy bank idle", cmd_valid, 0);
      @(posedge clk); #1;
      push(2'd1, 8'd4, 6'd0, 1'b0, 4'd6);
      @(negedge clk);
      check(cmd_valid && cmd_kind == 2'd0 && cmd_bank == 2'd1 && cmd_id == 4'd6,
            "R8 R3 free bank activates", {cmd_valid, cmd_kind, cmd_bank, cmd_id}, {1'b1, 2'd0, 2'd1, 4'd6});
      check(cmd_row == 8'd4, "R3 activate row", cmd_row, 4);
      @(posedge clk); #1;

      // R7: arrival order blocks behind a busy oldest request
      do_reset();
      fr_mode   = 1'b0;
      bank_busy = 4'b0100;
      push(2'd2, 8'd1, 6'd0, 1'b0, 4'd1);
      push(2'd1, 8'd2, 6'd0, 1'b0, 4'd2);
      @(negedge clk);
      check(cmd_valid === 1'b0, "R7 head blocked", cmd_valid, 0);
      @(posedge clk); #1;
      bank_busy = '0;
      @(negedge clk);
      check(cmd_valid && cmd_kind == 2'd0 && cmd_bank == 2'd2 && cmd_id == 4'd1,
            "R7 head served first", {cmd_valid, cmd_kind, cmd_bank, cmd_id}, {1'b1, 2'd0, 2'd2, 4'd1});
      @(posedge clk); #1;

      // table walk: same load under both policies
      for (int i = 0; i < 18; i++) begin
         if (i == 0 || i == 9) begin
            do_reset();
            fr_mode   = (i == 0);
            bank_busy = '1;
            load_set();
            bank_busy = '0;
         end
         @(negedge clk);
         ev = EXP_TAB[i];
         if (ev[8])
            check(cmd_valid && cmd_kind == ev[7:6] && cmd_bank == ev[5:4] && cmd_id == ev[3:0],
                  (i < 9) ? "R3 R4 R5 R6 table" : "R3 R4 R5 R7 table",
                  {cmd_valid, cmd_kind, cmd_bank, cmd_id}, ev);
         else
            check(cmd_valid === 1'b0, "R10 table idle", cmd_valid, 0);
         @(posedge clk); #1;
      end

      // R2: fill, reject when full, drain
      do_reset();
      fr_mode   = 1'b1;
      bank_busy = '1;
      for (int i = 0; i < 8; i++)
         push(2'(i), 8'(i), 6'(i), i[0], 4'(i));
      @(negedge clk);
      check(req_ready === 1'b0, "R2 ready low when full", req_ready, 0);
      @(posedge clk); #1;
      push(2'd1, 8'd9, 6'd9, 1'b0, 4'd9);
      bank_busy    = '0;
      col_cnt      = 0;
      saw_rejected = 1'b0;
      bad_col      = 1'b0;
      for (int c = 0; c < 64; c++) begin
         @(negedge clk);
         if (cmd_valid && cmd_id == 4'd9) saw_rejected = 1'b1;
         if (cmd_valid && cmd_kind[1]) begin
            col_cnt++;
            if (cmd_col != 6'(cmd_id)) bad_col = 1'b1;
         end
         @(posedge clk); #1;
      end
      check(col_cnt == 8, "R2 R5 drained count", col_cnt, 8);
      check(!saw_rejected, "R2 rejected request never issued", saw_rejected, 0);
      check(!bad_col, "R5 column matches request", bad_col, 0);
      @(negedge clk);
      check(cmd_valid === 1'b0, "R10 idle when empty", cmd_valid, 0);
      check(req_ready === 1'b1, "R2 ready after drain", req_ready, 1);
      @(posedge clk); #1;

      // R9: stamp wrap
      do_reset();
      fr_mode = 1'b0;
      bad_col = 1'b0;
      for (int k = 0; k < 29; k++) begin
         bank_busy = '1;
         push(2'd0, 8'd5, 6'd0, 1'b0, 4'(k));
         bank_busy = '0;
         got = 1'b0;
         for (int c = 0; c < 4 && !got; c++) begin
            @(negedge clk);
            if (cmd_valid && cmd_kind[1]) got = 1'b1;
            @(posedge clk); #1;
         end
         if (!got) bad_col = 1'b1;
      end
      check(!bad_col, "R5 single requests retire", bad_col, 0);
      bank_busy = '1;
      push(2'd0, 8'd9, 6'd1, 1'b0, 4'd10);
      push(2'd1, 8'd2, 6'd2, 1'b1, 4'd11);
      push(2'd2, 8'd3, 6'd3, 1'b0, 4'd12);
      push(2'd3, 8'd4, 6'd4, 1'b1, 4'd13);
      bank_busy = '0;
      @(negedge clk);
      check(cmd_valid && cmd_kind == 2'd1 && cmd_bank == 2'd0 && cmd_id == 4'd10,
            "R9 oldest before wrap served first", {cmd_valid, cmd_kind, cmd_bank, cmd_id}, {1'b1, 2'd1, 2'd0, 4'd10});
      @(posedge clk); #1;
      col_cnt = 0;
      last_id = '0;
      for (int c = 0; c < 20; c++) begin
         @(negedge clk);
         if (cmd_valid && cmd_kind[1]) begin
            col_cnt++;
            last_id = cmd_id;
         end
         @(posedge clk); #1;
      end
      check(col_cnt == 4, "R9 all four retired", col_cnt, 4);
      check(last_id == 4'd13, "R9 wrapped stamp served last", last_id, 13);

      finish_run();
   end

endmodule